// File: doc/BRIEF.md
# Flash Operation Status Bit Generator

This block sits on the flash side of the bus. It produces the status word that a read returns while an internal program, erase or buffered program is running. An internal sequencer reports when an operation starts, each program or erase pulse, a normal finish, and a buffered-program abort. The bus side supplies read strobes and the two reset commands. When the device is idle, reads pass array data through. When an operation is running or has failed, reads return a status word. In that word, bit 6 inverts on every read, bit 5 flags a pulse-limit failure and bit 1 flags a buffered-program abort.

When an operation starts, the block compares the requested data with the stored data. If any bit would have to rise from 0 to 1, the operation can never finish. Its finish report is then refused and the pulse counter runs on to the limit, so the request ends as a timing failure. A failure state is held until its own reset command arrives; the other reset command has no effect on it. After a pulse-limit failure during a program issued inside an erase suspend, the reset returns to suspend-read, which the block reports on a separate output.

Top module: `opstat_gen`

## Requirements
- R1: After reset, mode is 0 (array), `rd_valid` is 0 and `susp_read` is 0. Every read strobe yields `rd_valid` and `rd_data` one cycle later. In array mode `rd_data` equals `array_data` as sampled with the strobe.
- R2: In any non-array mode a read returns a status word. Bit 6 holds the toggle bit, which is 0 for the first read after an operation start and inverts with each later status read. Every bit other than 6, 5 and 1 reads 0.
- R3: In busy mode (mode 1), `op_done` returns the block to array mode, and later reads return array data.
- R4: `op_kind` encodes 0 program, 1 erase, 2 buffered program, 3 program during erase suspend. In busy mode, the PULSE_LIMIT-th `pulse` without a finish enters fail mode (mode 2). PULSE_LIMIT-1 pulses leave the block busy.
- R5: A start of kind 0, 2 or 3 whose `prog_data` has a 1 where `cell_data` has a 0 makes `op_done` ignored. The operation then ends only through the pulse limit.
- R6: An erase start never takes the 0-to-1 path; its `op_done` is honoured whatever the data.
- R7: In fail mode, status reads return bit 5 = 1 with bit 6 still toggling. `abort_rst_cmd` leaves fail mode unchanged.
- R8: `rst_cmd` in fail mode returns to array mode. `susp_read` becomes 1 only if the failed kind was 3, and it clears on the next accepted start.
- R9: `wbuf_abort` in busy mode for kind 2 enters abort mode (mode 3), where status reads return bit 1 = 1. For any other kind it is ignored.
- R10: In abort mode `rst_cmd` and `pulse` are ignored. Only `abort_rst_cmd` returns to array mode.
- R11: `op_start` is accepted only in array mode.
- R12: If several events coincide in busy mode, an accepted abort wins over an accepted finish, and an accepted finish wins over reaching the pulse limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Sequencer starts an operation |
| op_kind | input | 2 | Operation kind, sampled with `op_start` |
| prog_data | input | DATA_W | Data requested to be programmed |
| cell_data | input | DATA_W | Data currently stored at the target |
| pulse | input | 1 | One program or erase pulse has been applied |
| op_done | input | 1 | Sequencer reports a normal finish |
| wbuf_abort | input | 1 | Sequencer reports a buffered-program abort |
| rst_cmd | input | 1 | Reset command decoded from the bus |
| abort_rst_cmd | input | 1 | Abort-reset command sequence decoded from the bus |
| rd_stb | input | 1 | Bus read strobe |
| array_data | input | DATA_W | Array read data |
| rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| rd_data | output | DATA_W | Array data or status word |
| mode | output | 2 | 0 array, 1 busy, 2 fail, 3 abort |
| susp_read | output | 1 | Returned to erase-suspend read |

## Verification
Every event input is sampled at a rising edge, and its effect on `mode` and `susp_read` is visible right after that edge. The bench drives inputs on the falling edge and reads these outputs at the following falling edge. A read strobe is answered one edge later: the data reflects the mode and toggle bit as they stood before that edge, so a strobe issued together with a start still returns array data. The driver pushes the expected word of each read into a queue from its own model, built before the edge that samples the strobe. A monitor pops that word on the falling edge where `rd_valid` is high, which keeps every read one cycle behind its strobe.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_BUSY  = 2'd1,
    MODE_FAIL  = 2'd2,
    MODE_ABORT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    OP_PROG      = 2'd0,
    OP_ERASE     = 2'd1,
    OP_WBUF      = 2'd2,
    OP_SUSP_PROG = 2'd3
  } op_e;

  localparam int BIT_TOGGLE = 6;
  localparam int BIT_LIMIT  = 5;
  localparam int BIT_ABORT  = 1;

  // A request is unreachable when any bit must rise from 0 to 1.
  function automatic logic needs_raise(input logic [63:0] want, input logic [63:0] have);
    return |(want & ~have);
  endfunction

  // Only erase may raise bits, so only non-erase kinds can be stuck.
  function automatic logic kind_programs(input op_e kind);
    return kind != OP_ERASE;
  endfunction

  function automatic logic [7:0] status_byte(input logic tog, input logic lim, input logic abt);
    logic [7:0] s;
    s = '0;
    s[BIT_TOGGLE] = tog;
    s[BIT_LIMIT]  = lim;
    s[BIT_ABORT]  = abt;
    return s;
  endfunction

endpackage

// File: rtl/opstat_pulse_cnt.sv
module opstat_pulse_cnt #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic at_last
);
  localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear)    cnt_q <= '0;
    else if (step)     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/opstat_ctrl.sv
module opstat_ctrl
  import opstat_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LIMIT  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] cell_data,
  input  logic              pulse,
  input  logic              op_done,
  input  logic              wbuf_abort,
  input  logic              rst_cmd,
  input  logic              abort_rst_cmd,
  output mode_e             mode_q,
  output logic              susp_q,
  output logic              start_ok,
  output logic              abort_ok,
  output logic              done_ok,
  output logic              limit_hit,
  output logic              clr_fail,
  output logic              clr_abort
);
  op_e   kind_q;
  logic  stuck_q;
  logic  at_last;
  logic  busy;
  logic  start_stuck;
  mode_e mode_d;

  assign busy        = (mode_q == MODE_BUSY);
  assign start_ok    = (mode_q == MODE_ARRAY) && op_start;
  assign start_stuck = kind_programs(op_e'(op_kind)) &&
                       needs_raise(64'(prog_data), 64'(cell_data));
  assign abort_ok    = busy && wbuf_abort && (kind_q == OP_WBUF);
  assign done_ok     = busy && op_done && !stuck_q;
  assign limit_hit   = busy && pulse && at_last;
  assign clr_fail    = (mode_q == MODE_FAIL) && rst_cmd;
  assign clr_abort   = (mode_q == MODE_ABORT) && abort_rst_cmd;

  opstat_pulse_cnt #(.LIMIT(LIMIT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_ok),
    .step    (busy && pulse),
    .at_last (at_last)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_ARRAY: if (start_ok) mode_d = MODE_BUSY;
      MODE_BUSY: begin
        if (abort_ok)       mode_d = MODE_ABORT;
        else if (done_ok)   mode_d = MODE_ARRAY;
        else if (limit_hit) mode_d = MODE_FAIL;
      end
      MODE_FAIL:  if (clr_fail)  mode_d = MODE_ARRAY;
      MODE_ABORT: if (clr_abort) mode_d = MODE_ARRAY;
      default:    mode_d = MODE_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_ARRAY;
      kind_q  <= OP_PROG;
      stuck_q <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (start_ok) begin
        kind_q  <= op_e'(op_kind);
        stuck_q <= start_stuck;
        susp_q  <= 1'b0;
      end else if (clr_fail) begin
        susp_q <= (kind_q == OP_SUSP_PROG);
      end
    end
  end
endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic flip,
  output logic tog_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tog_q <= 1'b0;
    else if (clear) tog_q <= 1'b0;
    else if (flip)  tog_q <= ~tog_q;
  end
endmodule

// File: rtl/opstat_readout.sv
module opstat_readout
  import opstat_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  mode_e             mode_q,
  input  logic              tog_q,
  input  logic [DATA_W-1:0] array_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] status_w;

  assign status_w = DATA_W'(status_byte(tog_q, mode_q == MODE_FAIL, mode_q == MODE_ABORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= (mode_q == MODE_ARRAY) ? array_data : status_w;
    end
  end
endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
  import opstat_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PULSE_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [DATA_W-1:0] cell_data,
  input  logic              pulse,
  input  logic              op_done,
  input  logic              wbuf_abort,
  input  logic              rst_cmd,
  input  logic              abort_rst_cmd,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] array_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        mode,
  output logic              susp_read
);
  mode_e mode_q;
  logic  tog_q;
  logic  start_ok, abort_ok, done_ok, limit_hit, clr_fail, clr_abort;
  logic  status_rd;

  assign status_rd = rd_stb && (mode_q != MODE_ARRAY);

  opstat_ctrl #(.DATA_W(DATA_W), .LIMIT(PULSE_LIMIT)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_start      (op_start),
    .op_kind       (op_kind),
    .prog_data     (prog_data),
    .cell_data     (cell_data),
    .pulse         (pulse),
    .op_done       (op_done),
    .wbuf_abort    (wbuf_abort),
    .rst_cmd       (rst_cmd),
    .abort_rst_cmd (abort_rst_cmd),
    .mode_q        (mode_q),
    .susp_q        (susp_read),
    .start_ok      (start_ok),
    .abort_ok      (abort_ok),
    .done_ok       (done_ok),
    .limit_hit     (limit_hit),
    .clr_fail      (clr_fail),
    .clr_abort     (clr_abort)
  );

  opstat_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_ok),
    .flip  (status_rd),
    .tog_q (tog_q)
  );

  opstat_readout #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .mode_q     (mode_q),
    .tog_q      (tog_q),
    .array_data (array_data),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  assign mode = mode_q;
endmodule

// File: rtl/opstat_gen_chk.sv
module opstat_gen_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] array_data,
  input logic [1:0]        mode,
  input logic              tog,
  input logic              op_start,
  input logic              rst_cmd,
  input logic              abort_rst_cmd,
  input logic              abort_ok,
  input logic              done_ok,
  input logic              limit_hit
);
  assert_rd_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);

  assert_array_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode == 2'd0) |=> (rd_data == $past(array_data)));

  assert_toggle_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && mode != 2'd0 && !op_start) |=> (tog != $past(tog)));

  assert_limit_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_hit && !abort_ok && !done_ok) |=> (mode == 2'd2));

  assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !rst_cmd) |=> (mode == 2'd2));

  assert_abort_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !abort_rst_cmd) |=> (mode == 2'd3));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !op_start) |=> (mode == 2'd0));

  assert_abort_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ok |=> (mode == 2'd3));
endmodule

bind opstat_gen opstat_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_stb        (rd_stb),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data),
  .array_data    (array_data),
  .mode          (mode),
  .tog           (tog_q),
  .op_start      (op_start),
  .rst_cmd       (rst_cmd),
  .abort_rst_cmd (abort_rst_cmd),
  .abort_ok      (abort_ok),
  .done_ok       (done_ok),
  .limit_hit     (limit_hit)
);

// File: tb/opstat_gen_bench.sv
`timescale 1ns/1ps
module opstat_gen_bench;
  localparam int DW  = 16;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 0, pulse = 0, op_done = 0, wbuf_abort = 0;
  logic rst_cmd = 0, abort_rst_cmd = 0, rd_stb = 0;
  logic [1:0] op_kind = 2'd0;
  logic [DW-1:0] prog_data = '0, cell_data = '0, array_data = '0;
  logic rd_valid, susp_read;
  logic [DW-1:0] rd_data;
  logic [1:0] mode;

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  // bench model
  int m_mode = 0, m_kind = 0, m_cnt = 0;
  bit m_tog = 0, m_stuck = 0, m_susp = 0;

  always #10 clk = ~clk;

  opstat_gen #(.DATA_W(DW), .PULSE_LIMIT(LIM)) u_opstat_gen (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .prog_data(prog_data), .cell_data(cell_data), .pulse(pulse),
    .op_done(op_done), .wbuf_abort(wbuf_abort), .rst_cmd(rst_cmd),
    .abort_rst_cmd(abort_rst_cmd), .rd_stb(rd_stb), .array_data(array_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .mode(mode), .susp_read(susp_read)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle with the currently driven inputs; model follows requirements
  task automatic step(input string tag);
    logic [DW-1:0] e;
    if (rd_stb) begin
      if (m_mode == 0) e = array_data;
      else begin
        e = '0;
        e[6] = m_tog;
        e[5] = (m_mode == 2);
        e[1] = (m_mode == 3);
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (m_mode != 0) m_tog = ~m_tog;
    end
    case (m_mode)
      0: if (op_start) begin
           m_mode = 1; m_kind = int'(op_kind); m_cnt = 0; m_tog = 0; m_susp = 0;
           m_stuck = (op_kind != 2'd1) && ((prog_data & ~cell_data) != '0);
         end
      1: if (wbuf_abort && m_kind == 2) m_mode = 3;
         else if (op_done && !m_stuck) m_mode = 0;
         else if (pulse) begin
           m_cnt++;
           if (m_cnt == LIM) m_mode = 2;
         end
      2: if (rst_cmd) begin m_mode = 0; m_susp = (m_kind == 3); end
      3: if (abort_rst_cmd) m_mode = 0;
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    op_start = 0; pulse = 0; op_done = 0; wbuf_abort = 0;
    rst_cmd = 0; abort_rst_cmd = 0; rd_stb = 0;
  endtask

  task automatic t_read(input string tag, input logic [DW-1:0] ad);
    rd_stb = 1; array_data = ad; step(tag);
  endtask
  task automatic t_start(input string tag, input int k, input logic [DW-1:0] pd, input logic [DW-1:0] cd);
    op_start = 1; op_kind = 2'(k); prog_data = pd; cell_data = cd; step(tag);
  endtask
  task automatic t_pulses(input string tag, input int n);
    for (int i = 0; i < n; i++) begin pulse = 1; step(tag); end
  endtask
  task automatic t_mode(input string tag);
    chk({tag, " mode"}, int'(mode), m_mode);
  endtask

  // monitor: pop expected read words as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL read unexpected actual=%0h expected=none", rd_data);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL %s read actual=%0h expected=%0h", t, rd_data, e);
        end
      end
    end
  end

  bit finished = 0;
  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and array pass-through
    chk("R1 mode", int'(mode), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 susp", int'(susp_read), 0);
    t_read("R1", 16'hA5C3);
    t_read("R1", 16'h5A3C);

    // R2/R3 normal program, status toggles then finishes
    t_start("R2", 0, 16'h00FF, 16'hFFFF);
    t_mode("R2");
    for (int i = 0; i < 4; i++) t_read("R2", 16'h1234);
    t_pulses("R3", 3);
    op_done = 1; step("R3");
    t_mode("R3");
    t_read("R3", 16'hBEEF);

    // R6 erase never stuck; R4 LIMIT-1 pulses stay busy
    t_start("R6", 1, 16'hFFFF, 16'h0000);
    t_pulses("R4", LIM - 1);
    t_mode("R4");
    op_done = 1; step("R6");
    t_mode("R6");

    // R5 zero-to-one program fails through the limit
    t_start("R5", 0, 16'h0001, 16'h0000);
    op_done = 1; step("R5");
    t_mode("R5");
    t_pulses("R5", LIM - 1);
    t_mode("R5");
    t_pulses("R5", 1);
    t_mode("R5");
    for (int i = 0; i < 3; i++) t_read("R7", 16'h0F0F);
    abort_rst_cmd = 1; step("R7");
    t_mode("R7");
    t_start("R11", 0, 16'h0000, 16'hFFFF);
    t_mode("R11");
    t_read("R7", 16'h0F0F);
    rst_cmd = 1; step("R8");
    t_mode("R8");
    chk("R8 susp", int'(susp_read), 0);

    // R4/R8 suspend-program reaches limit, returns to suspend read
    t_start("R4", 3, 16'h0000, 16'hFFFF);
    t_pulses("R4", LIM);
    t_mode("R4");
    rst_cmd = 1; step("R8");
    t_mode("R8");
    chk("R8 susp set", int'(susp_read), 1);
    t_start("R8", 0, 16'h0000, 16'hFFFF);
    chk("R8 susp clear", int'(susp_read), 0);

    // R9 abort ignored on a plain program
    wbuf_abort = 1; step("R9");
    t_mode("R9");
    op_done = 1; step("R9");
    t_mode("R9");

    // R9/R10 buffered program abort
    t_start("R9", 2, 16'h0000, 16'hFFFF);
    t_read("R9", 16'h1111);
    wbuf_abort = 1; step("R9");
    t_mode("R9");
    t_read("R9", 16'h2222);
    t_read("R9", 16'h2222);
    rst_cmd = 1; step("R10");
    t_mode("R10");
    t_pulses("R10", LIM);
    t_mode("R10");
    abort_rst_cmd = 1; step("R10");
    t_mode("R10");
    t_read("R10", 16'h3333);

    // R12 priority: abort over finish over limit
    t_start("R12", 2, 16'h0000, 16'hFFFF);
    t_pulses("R12", LIM - 1);
    wbuf_abort = 1; op_done = 1; pulse = 1; step("R12");
    t_mode("R12");
    abort_rst_cmd = 1; step("R12");
    t_start("R12", 2, 16'h0000, 16'hFFFF);
    t_pulses("R12", LIM - 1);
    op_done = 1; pulse = 1; step("R12");
    t_mode("R12");

    // R11 start ignored while busy; start with read returns array data
    t_start("R11", 1, 16'h0000, 16'h0000);
    t_start("R11", 2, 16'h0000, 16'hFFFF);
    wbuf_abort = 1; step("R11");
    t_mode("R11");
    op_done = 1; step("R11");
    rd_stb = 1; array_data = 16'h7777; op_start = 1; op_kind = 2'd0;
    prog_data = '0; cell_data = '1; step("R1");
    t_read("R2", 16'h7777);
    op_done = 1; step("R3");

    @(negedge clk);
    chk("R1 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule